// File: doc/BRIEF.md
# Memory-Backed SPI Master with APB Register Port

This block is an SPI master whose data lives in two internal word memories. A host on an APB port loads 32-bit words into a transmit memory, writes a control register with a word count and a go bit, and later reads the words returned by the SPI device out of a receive memory. Once the go bit is set, a sequencer fetches words from transmit memory in index order and shifts each one out on `mosi`, most significant bit first. It raises `mosi_vld` for the whole burst and generates `sclk` at half the APB clock rate. At the same time it gathers 32 bits from `miso` for each word and writes the result into the receive memory at the same index.

A host runs several bursts by writing a new count and go bit after each burst has finished. Every burst starts again at index 0 of both memories. The control register also reports whether a burst is in progress, so the host can poll it.

Top module: `spi_pkt_ctrl`

## Requirements
- R1: After reset, every transmit and receive memory word reads 0, the control register reads 0, and `sclk`, `mosi` and `mosi_vld` are low.
- R2: An APB write to word address 0..63 stores `pwdata` in transmit memory at that index, and a read of that address returns the stored word. `pready` is always high, so there are no wait states.
- R3: The control register is at word address 64. Bits [5:0] hold the word count, bit 6 reads 1 while a burst is running, bit 7 reads 1 while busy, and the other bits read 0.
- R4: While idle, a control write with bit 6 = 1 and a nonzero count starts a burst at the edge of that write. Bits 6 and 7 read 1 until the last word is finished, then both read 0.
- R5: A burst of N words keeps `mosi_vld` high for exactly N*64 APB clock cycles. It sends transmit words 0..N-1 in order, 32 bits each, MSB first. `sclk` idles low, stays high for one cycle and low for one cycle in turn, and `mosi` changes only while `sclk` is low.
- R6: `miso` is sampled on each `sclk` rising edge. The 32 bits of word k, MSB first, are written to receive index k, which is readable at word address 66+k.
- R7: A control write with bit 6 = 1 and count 0 finishes at once. `sclk` does not toggle and the busy bit stays 0.
- R8: Any control-register write while busy is ignored. The count does not change and no new burst starts.
- R9: Every burst starts at index 0. Receive words at indices greater than or equal to the count keep their earlier contents.
- R10: Addresses 65 and 130 and above read 0. Writes to them, and writes to the receive range, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB word address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to the device |
| mosi_vld | output | 1 | High while a burst is shifting |
| miso | input | 1 | Serial data from the device |

## Verification
The host's APB traffic and the sequencer's shifting can fall in the same cycle. Polling reads of the control register and receive memory overlap word write-backs. A second go write arrives while a burst is running. The bench issues such a go write mid-burst with a different count and then reads the register back to confirm the count has not changed. It then judges the whole burst by the active-cycle length, the words the modelled device received, and the receive contents against a model in which the device echoes its previous word.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;
  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;
endpackage

// File: rtl/spi_pkt_mem.sv
module spi_pkt_mem #(
  parameter int W  = 32,
  parameter int D  = 64,
  parameter int RP = 1,
  localparam int AW = $clog2(D)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [W-1:0]          wdata,
  input  logic [RP-1:0][AW-1:0] raddr,
  output logic [RP-1:0][W-1:0]  rdata
);
  logic [W-1:0] mem_q [D];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < RP; g++) begin : g_rd
    assign rdata[g] = mem_q[raddr[g]];
  end
endmodule

// File: rtl/spi_pkt_seq.sv
module spi_pkt_seq
  import spi_pkt_pkg::*;
#(
  parameter int W = 32,
  parameter int D = 64,
  localparam int CW = $clog2(D),
  localparam int BW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] start_cnt,
  output logic [CW-1:0] tx_idx,
  input  logic [W-1:0]  tx_word,
  output logic          rx_we,
  output logic [CW-1:0] rx_idx,
  output logic [W-1:0]  rx_word,
  output logic          busy,
  output logic          sclk,
  output logic          mosi,
  output logic          mosi_vld,
  input  logic          miso
);
  localparam logic [BW-1:0] BIT_LAST = BW'(W - 1);

  seq_state_e    st_q, st_n;
  logic          ph_q, ph_n;
  logic [BW-1:0] bit_q, bit_n;
  logic [CW-1:0] widx_q, widx_n, last_q, last_n;
  logic [W-1:0]  txs_q, txs_n, rxs_q, rxs_n;

  always_comb begin
    st_n   = st_q;
    ph_n   = ph_q;
    bit_n  = bit_q;
    widx_n = widx_q;
    last_n = last_q;
    txs_n  = txs_q;
    rxs_n  = rxs_q;
    rx_we  = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          st_n   = SEQ_RUN;
          ph_n   = 1'b0;
          bit_n  = '0;
          widx_n = '0;
          last_n = start_cnt - 1'b1;
          txs_n  = tx_word;
        end
      end
      SEQ_RUN: begin
        if (!ph_q) begin
          ph_n  = 1'b1;
          rxs_n = {rxs_q[W-2:0], miso};
        end else begin
          ph_n = 1'b0;
          if (bit_q == BIT_LAST) begin
            rx_we = 1'b1;
            bit_n = '0;
            if (widx_q == last_q) begin
              st_n = SEQ_IDLE;
            end else begin
              widx_n = widx_q + 1'b1;
              txs_n  = tx_word;
            end
          end else begin
            bit_n = bit_q + 1'b1;
            txs_n = {txs_q[W-2:0], 1'b0};
          end
        end
      end
      default: st_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      ph_q   <= 1'b0;
      bit_q  <= '0;
      widx_q <= '0;
      last_q <= '0;
      txs_q  <= '0;
      rxs_q  <= '0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      bit_q  <= bit_n;
      widx_q <= widx_n;
      last_q <= last_n;
      txs_q  <= txs_n;
      rxs_q  <= rxs_n;
    end
  end

  assign busy     = (st_q == SEQ_RUN);
  assign mosi_vld = busy;
  assign sclk     = ph_q;
  assign mosi     = busy & txs_q[W-1];
  assign tx_idx   = busy ? CW'(widx_q + 1'b1) : '0;
  assign rx_idx   = widx_q;
  assign rx_word  = rxs_q;
endmodule

// File: rtl/spi_pkt_ctrl.sv
module spi_pkt_ctrl #(
  parameter int DEPTH = 64,
  parameter int WORD  = 32,
  parameter int PAW   = 8
) (
  input  logic            pclk,
  input  logic            presetn,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [PAW-1:0]  paddr,
  input  logic [WORD-1:0] pwdata,
  output logic [WORD-1:0] prdata,
  output logic            pready,
  output logic            sclk,
  output logic            mosi,
  output logic            mosi_vld,
  input  logic            miso
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [PAW-1:0] CTRL_A = PAW'(DEPTH);
  localparam logic [PAW-1:0] RX_A   = PAW'(DEPTH + 2);
  localparam logic [PAW-1:0] RX_E   = PAW'(2 * DEPTH + 2);

  logic [1:0]  rst_sync_q;
  logic        rst_n;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic wr_en, tx_hit, ctrl_hit, rx_hit, ctrl_wr, launch, busy;
  logic [AW-1:0] cnt_q, cnt_n, seq_tx_idx, seq_rx_idx;
  logic [WORD-1:0] seq_rx_word;
  logic seq_rx_we;
  logic [1:0][AW-1:0]   tx_ra;
  logic [1:0][WORD-1:0] tx_rd;
  logic [0:0][AW-1:0]   rx_ra;
  logic [0:0][WORD-1:0] rx_rd;

  assign wr_en    = psel & penable & pwrite;
  assign tx_hit   = (paddr < CTRL_A);
  assign ctrl_hit = (paddr == CTRL_A);
  assign rx_hit   = (paddr >= RX_A) && (paddr < RX_E);
  assign ctrl_wr  = wr_en & ctrl_hit & ~busy;
  assign launch   = ctrl_wr & pwdata[AW] & (|pwdata[AW-1:0]);
  assign cnt_n    = ctrl_wr ? pwdata[AW-1:0] : cnt_q;

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign tx_ra[1] = paddr[AW-1:0];
  assign tx_ra[0] = seq_tx_idx;
  assign rx_ra[0] = AW'(paddr - RX_A);

  spi_pkt_mem #(.W(WORD), .D(DEPTH), .RP(2)) u_txmem (
    .clk(pclk), .rst_n(rst_n), .we(wr_en & tx_hit), .waddr(paddr[AW-1:0]),
    .wdata(pwdata), .raddr(tx_ra), .rdata(tx_rd)
  );

  spi_pkt_mem #(.W(WORD), .D(DEPTH), .RP(1)) u_rxmem (
    .clk(pclk), .rst_n(rst_n), .we(seq_rx_we), .waddr(seq_rx_idx),
    .wdata(seq_rx_word), .raddr(rx_ra), .rdata(rx_rd)
  );

  spi_pkt_seq #(.W(WORD), .D(DEPTH)) u_seq (
    .clk(pclk), .rst_n(rst_n), .start(launch), .start_cnt(pwdata[AW-1:0]),
    .tx_idx(seq_tx_idx), .tx_word(tx_rd[0]), .rx_we(seq_rx_we),
    .rx_idx(seq_rx_idx), .rx_word(seq_rx_word), .busy(busy),
    .sclk(sclk), .mosi(mosi), .mosi_vld(mosi_vld), .miso(miso)
  );

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (tx_hit)        prdata = tx_rd[1];
      else if (ctrl_hit) prdata = WORD'({busy, busy, cnt_q});
      else if (rx_hit)   prdata = rx_rd[0];
    end
  end

  assign pready = 1'b1;
endmodule

// File: rtl/spi_pkt_chk.sv
module spi_pkt_chk #(
  parameter int DEPTH = 64,
  parameter int WORD  = 32,
  parameter int PAW   = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input logic            pclk,
  input logic            rst_n,
  input logic            psel,
  input logic            penable,
  input logic            pwrite,
  input logic [PAW-1:0]  paddr,
  input logic [WORD-1:0] pwdata,
  input logic            sclk,
  input logic            mosi,
  input logic            mosi_vld,
  input logic            busy,
  input logic [AW-1:0]   cnt
);
  logic ctrl_w;
  assign ctrl_w = psel && penable && pwrite && (paddr == PAW'(DEPTH));

  assert_sclk_idle_R5: assert property (@(posedge pclk) disable iff (!rst_n)
    !mosi_vld |-> !sclk);
  assert_sclk_alt_R5: assert property (@(posedge pclk) disable iff (!rst_n)
    (mosi_vld && sclk) |=> !sclk);
  assert_mosi_hold_R5: assert property (@(posedge pclk) disable iff (!rst_n)
    (mosi_vld && !sclk) |=> $stable(mosi));
  assert_go_R4: assert property (@(posedge pclk) disable iff (!rst_n)
    (ctrl_w && !busy && pwdata[AW] && (pwdata[AW-1:0] != '0)) |=> (busy && mosi_vld && !sclk));
  assert_zero_cnt_R7: assert property (@(posedge pclk) disable iff (!rst_n)
    (ctrl_w && !busy && (pwdata[AW-1:0] == '0)) |=> !busy);
  assert_busy_ignore_R8: assert property (@(posedge pclk) disable iff (!rst_n)
    (ctrl_w && busy) |=> $stable(cnt));
endmodule

bind spi_pkt_ctrl spi_pkt_chk #(.DEPTH(DEPTH), .WORD(WORD), .PAW(PAW)) u_chk (
  .pclk(pclk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .sclk(sclk), .mosi(mosi), .mosi_vld(mosi_vld),
  .busy(busy), .cnt(cnt_q)
);

// File: tb/spi_pkt_ctrl_test.sv
module spi_pkt_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic pclk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0, miso;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic pready, sclk, mosi, mosi_vld;

  int errors = 0, checks = 0;
  int vld_cycles = 0, sclk_rises = 0;
  logic [31:0] tx_m [64];
  logic [31:0] rx_m [64];
  logic [31:0] slv_got [64];
  int slv_n = 0;
  logic [31:0] carry = 32'h5A5A_C3C3;

  // device model: shifts in on rising sclk, echoes previous word
  logic [31:0] in_sh = 0, in_word = 0, out_sh = 32'h5A5A_C3C3;
  logic [4:0] in_cnt = 0;
  assign miso = out_sh[31];

  always #(CLK_PERIOD/2) pclk = ~pclk;

  spi_pkt_ctrl uut (.pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .sclk(sclk), .mosi(mosi), .mosi_vld(mosi_vld), .miso(miso));

  always @(posedge sclk) begin
    sclk_rises <= sclk_rises + 1;
    if (mosi_vld) begin
      in_sh  <= {in_sh[30:0], mosi};
      in_cnt <= in_cnt + 1'b1;
      if (in_cnt == 5'd31) begin
        in_word <= {in_sh[30:0], mosi};
        slv_got[slv_n] <= {in_sh[30:0], mosi};
        slv_n <= slv_n + 1;
      end
    end
  end
  always @(negedge sclk) begin
    if (in_cnt == 5'd0) out_sh <= in_word;
    else                out_sh <= {out_sh[30:0], 1'b0};
  end
  always @(negedge pclk) if (mosi_vld) vld_cycles <= vld_cycles + 1;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge pclk); #1;
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(posedge pclk); #1; penable = 1;
    @(posedge pclk); #1; psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge pclk); #1;
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(posedge pclk); #1; penable = 1;
    @(negedge pclk); d = prdata;
    @(posedge pclk); #1; psel = 0; penable = 0;
  endtask

  function automatic logic [31:0] ctrl_val(input bit bsy, input int n);
    return {24'd0, bsy, bsy, 6'(n)};
  endfunction

  task automatic run_burst(input int n, input bit poke);
    logic [31:0] d;
    int guard = 0;
    vld_cycles = 0; slv_n = 0;
    apb_wr(8'd64, 32'h40 | 32'(n));
    apb_rd(8'd64, d);
    chk("R4 busy after go", d, ctrl_val(1, n));
    if (poke) begin
      apb_wr(8'd64, 32'h40 | 32'((n % 63) + 1 == n ? 1 : (n % 63) + 1));
      apb_rd(8'd64, d);
      chk("R8 write while busy ignored", d, ctrl_val(1, n));
    end
    do begin
      apb_rd(8'd64, d);
      guard++;
    end while (d[7] && guard < 20000);
    chk("R4 idle after burst", d, ctrl_val(0, n));
    chk("R5 valid cycle count", 32'(vld_cycles), 32'(n * 64));
    chk("R5 words sent", 32'(slv_n), 32'(n));
    for (int i = 0; i < n; i++) chk("R5 word order MSB first", slv_got[i], tx_m[i]);
    rx_m[0] = carry;
    for (int i = 1; i < n; i++) rx_m[i] = tx_m[i-1];
    carry = tx_m[n-1];
    for (int i = 0; i < 64; i++) begin
      apb_rd(8'(66 + i), d);
      chk((i < n) ? "R6 receive word" : "R9 untouched receive word", d, rx_m[i]);
    end
  endtask

  initial begin
    logic [31:0] d;
    int r0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) rx_m[i] = 0;
    repeat (3) @(posedge pclk);
    #1 presetn = 1;
    repeat (4) @(posedge pclk);
    #1;
    chk("R1 sclk", {31'd0, sclk}, 0);
    chk("R1 mosi_vld", {31'd0, mosi_vld}, 0);
    chk("R1 mosi", {31'd0, mosi}, 0);
    chk("R2 pready", {31'd0, pready}, 1);
    apb_rd(8'd5, d);  chk("R1 tx cleared", d, 0);
    apb_rd(8'd70, d); chk("R1 rx cleared", d, 0);
    apb_rd(8'd64, d); chk("R1 ctrl cleared", d, 0);

    for (int i = 0; i < 64; i++) begin
      tx_m[i] = $urandom;
      apb_wr(8'(i), tx_m[i]);
    end
    apb_rd(8'd0, d);  chk("R2 tx readback low", d, tx_m[0]);
    apb_rd(8'd63, d); chk("R2 tx readback high", d, tx_m[63]);
    apb_wr(8'd64, 32'd9);
    apb_rd(8'd64, d); chk("R3 count only", d, ctrl_val(0, 9));

    // zero count
    r0 = sclk_rises;
    apb_wr(8'd64, 32'h40);
    repeat (8) @(posedge pclk);
    apb_rd(8'd64, d); chk("R7 zero count idle", d, 0);
    chk("R7 no sclk", 32'(sclk_rises), 32'(r0));

    run_burst(1, 0);
    run_burst(63, 0);
    run_burst(5, 1);
    for (int k = 0; k < 4; k++) begin
      tx_m[k] = $urandom;
      apb_wr(8'(k), tx_m[k]);
      run_burst(2 + int'($urandom_range(0, 30)), k[0]);
    end

    // unmapped and read-only ranges
    apb_wr(8'd66, 32'hDEAD_BEEF);
    apb_rd(8'd66, d); chk("R10 rx write ignored", d, rx_m[0]);
    apb_wr(8'd65, 32'h1234_5678);
    apb_rd(8'd65, d); chk("R10 addr 65 reads 0", d, 0);
    apb_wr(8'd200, 32'h1);
    apb_rd(8'd200, d); chk("R10 high addr reads 0", d, 0);
    apb_rd(8'd1, d);  chk("R10 tx unchanged", d, tx_m[1]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule